// File: doc/BRIEF.md
# Performance-Bounded Cache Hierarchy Picker

This block picks one cache hierarchy from a fixed set of ten candidates. A one-cycle `start` pulse begins a scan. The block asks an external evaluator for the modeled run time and energy of each hierarchy, one hierarchy per request, and keeps the cheapest one whose time does not exceed the time of a fixed baseline hierarchy. The baseline has a 32 KB first level, a 256 KB second level and a 16 MB third level. It is always scored first and is the starting choice, so every scan ends with a valid answer.

Each hierarchy is described by three sizes in KB, one per cache level, and a size of zero marks a level that is missing. The candidate set is a build-time parameter. Before a candidate is sent to the evaluator, the block checks that each present level is at least twice the size of the nearest present level below it. A candidate that fails this check is never sent out and raises an error flag.

Top module: `hier_cfg_select`

## Requirements
- R1: After reset, `done`, `resValid`, `evalReq` and `cfgErr` are all 0.
- R2: The first request of every scan carries index 10 (the baseline) with sizes 32/256/16384.
- R3: After the baseline, candidates are requested in ascending index order from 0 to 9. Each request carries that entry's L1, L2 and L3 sizes. The default entries (L1/L2/L3, in KB) are: 0:16/256/0, 1:16/1024/0, 2:16/2048/0, 3:8/32/2048, 4:16/64/2048, 5:16/64/8192, 6:16/128/4096, 7:16/128/16384, 8:16/256/2048, 9:16/512/16384.
- R4: A candidate is eligible only when its returned time is less than or equal to the baseline's returned time. A slower candidate is rejected even when its energy is lower.
- R5: The result is the eligible candidate with the strictly lowest energy. When two candidates have equal energy, the lower index wins. A candidate whose energy equals the current best does not replace it.
- R6: When no eligible candidate has energy below the baseline's, the result is index 10 with the baseline's energy.
- R7: An entry is skipped and `cfgErr` is set when its L1 is zero, or when a nonzero L2 or L3 is smaller than twice the nearest nonzero level below it. A skipped entry is never requested. `cfgErr` clears on the next accepted `start`.
- R8: `evalReq` stays high with a stable index until `evalAck` is seen. `evalAck` has no effect while `evalReq` is low.
- R9: `done` is a one-cycle pulse. `resValid` rises together with `done`, stays high until the next accepted `start`, and is 0 during a scan. A `start` that arrives during a scan is ignored.
- R10: With evaluator latency L, the scan takes (L+1) cycles for the baseline, plus L+2 cycles for each valid candidate and 1 cycle for each skipped one. The count runs from the edge that samples `start` to the edge after which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| evalReq | output | 1 | Evaluation request |
| evalIdx | output | 4 | Index of the hierarchy being requested (10 = baseline) |
| evalL1 | output | 16 | First-level size in KB |
| evalL2 | output | 16 | Second-level size in KB (0 = absent) |
| evalL3 | output | 16 | Third-level size in KB (0 = absent) |
| evalAck | input | 1 | Evaluator response strobe |
| evalTime | input | 16 | Modeled time for the requested hierarchy |
| evalEnergy | input | 16 | Modeled energy for the requested hierarchy |
| done | output | 1 | Scan finished (one-cycle pulse) |
| resValid | output | 1 | Result fields are valid |
| resIdx | output | 4 | Selected index |
| resEnergy | output | 16 | Energy of the selected hierarchy |
| cfgErr | output | 1 | A table entry broke the doubling rule |

## Verification
A request appears one cycle after `start` is sampled. Each response is registered at the edge where `evalAck` is high, and the result fields and `done` become visible after the edge that ends the last request or the last skip. The bench counts edges from the start sample to `done`, computes the expected count from the latency and the number of skipped entries as R10 states, and samples every output on the falling edge. The evaluator model checks each request's index and sizes against its own copy of the table, in order. Results are compared in the cycle where `done` is high, and the next cycle confirms that `done` has dropped and `resValid` is still held.

// File: rtl/hier_sel_pkg.sv
package hier_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_REQ   = 2'd2,
    ST_DONE  = 2'd3
  } selState_t;

  typedef struct packed {
    logic init;     // begin a scan at the baseline
    logic take;     // capture an evaluator response
    logic step;     // advance to the next table entry
    logic markBad;  // entry failed the doubling rule
    logic finish;   // publish the result
  } selCtl_t;
endpackage

// File: rtl/hsel_ctrl.sv
module hsel_ctrl
  import hier_sel_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    evalAck,
  input  logic    curBad,
  input  logic    curLast,
  output selCtl_t ctl,
  output logic    evalReq,
  output logic    done
);
  selState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl = '0;
    case (state)
      ST_IDLE: if (start) begin
        ctl.init = 1'b1;
        nextState = ST_REQ;
      end
      ST_REQ: if (evalAck) begin
        ctl.take = 1'b1;
        if (curLast) begin
          ctl.finish = 1'b1;
          nextState = ST_DONE;
        end else begin
          ctl.step = 1'b1;
          nextState = ST_CHECK;
        end
      end
      ST_CHECK: if (curBad) begin
        ctl.markBad = 1'b1;
        if (curLast) begin
          ctl.finish = 1'b1;
          nextState = ST_DONE;
        end else begin
          ctl.step = 1'b1;
        end
      end else begin
        nextState = ST_REQ;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign evalReq = (state == ST_REQ);
  assign done    = (state == ST_DONE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evalReq && !evalAck) |=> evalReq);
endmodule

// File: rtl/hsel_path.sv
module hsel_path
  import hier_sel_pkg::*;
#(
  parameter int NUM_CAND = 10,
  parameter int SZW      = 16,
  parameter int TW       = 16,
  parameter int EW       = 16,
  parameter int IW       = 4,
  parameter logic [NUM_CAND*3*SZW-1:0] CAND_TABLE = '0,
  parameter int REF_L1   = 32,
  parameter int REF_L2   = 256,
  parameter int REF_L3   = 16384
)(
  input  logic           clk,
  input  logic           rstN,
  input  selCtl_t        ctl,
  input  logic [TW-1:0]  evalTime,
  input  logic [EW-1:0]  evalEnergy,
  output logic [IW-1:0]  curIdx,
  output logic [SZW-1:0] curL1,
  output logic [SZW-1:0] curL2,
  output logic [SZW-1:0] curL3,
  output logic           curBad,
  output logic           curLast,
  output logic [IW-1:0]  resIdx,
  output logic [EW-1:0]  resEnergy,
  output logic           resValid,
  output logic           cfgErr
);
  localparam logic [IW-1:0] REF_IDX  = IW'(NUM_CAND);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CAND - 1);
  localparam int ENT_W = 3 * SZW;

  logic [SZW-1:0] tabL1 [NUM_CAND];
  logic [SZW-1:0] tabL2 [NUM_CAND];
  logic [SZW-1:0] tabL3 [NUM_CAND];

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_unpack
    assign tabL1[g] = CAND_TABLE[g*ENT_W         +: SZW];
    assign tabL2[g] = CAND_TABLE[g*ENT_W + SZW   +: SZW];
    assign tabL3[g] = CAND_TABLE[g*ENT_W + 2*SZW +: SZW];
  end

  function automatic logic ladderOk(input logic [SZW-1:0] a,
                                    input logic [SZW-1:0] b,
                                    input logic [SZW-1:0] c);
    logic [SZW+1:0] floorSz;
    logic ok;
    ok = (a != '0);
    floorSz = {2'b00, a};
    if (b != '0) begin
      if ({2'b00, b} < (floorSz << 1)) ok = 1'b0;
      floorSz = {2'b00, b};
    end
    if (c != '0) begin
      if ({2'b00, c} < (floorSz << 1)) ok = 1'b0;
    end
    return ok;
  endfunction

  always_comb begin
    if (curIdx < REF_IDX) begin
      curL1 = tabL1[curIdx];
      curL2 = tabL2[curIdx];
      curL3 = tabL3[curIdx];
    end else begin
      curL1 = SZW'(REF_L1);
      curL2 = SZW'(REF_L2);
      curL3 = SZW'(REF_L3);
    end
  end

  assign curBad  = !ladderOk(curL1, curL2, curL3);
  assign curLast = (curIdx == LAST_IDX);

  logic [TW-1:0] refTime;
  logic [EW-1:0] bestE;
  logic [IW-1:0] bestIdx;
  logic          onRef;
  logic          beats;

  assign onRef = (curIdx == REF_IDX);
  assign beats = (evalTime <= refTime) && (evalEnergy < bestE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      refTime  <= '0;
      bestE    <= '0;
      bestIdx  <= '0;
      resValid <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      if (ctl.init) begin
        curIdx   <= REF_IDX;
        cfgErr   <= 1'b0;
        resValid <= 1'b0;
      end
      if (ctl.take) begin
        if (onRef) begin
          refTime <= evalTime;
          bestE   <= evalEnergy;
          bestIdx <= REF_IDX;
        end else if (beats) begin
          bestE   <= evalEnergy;
          bestIdx <= curIdx;
        end
      end
      if (ctl.step)    curIdx   <= onRef ? '0 : curIdx + 1'b1;
      if (ctl.markBad) cfgErr   <= 1'b1;
      if (ctl.finish)  resValid <= 1'b1;
    end
  end

  assign resIdx    = bestIdx;
  assign resEnergy = bestE;

  // R5
  best_energy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && !onRef) |=> (bestE <= $past(bestE)));

  // R7
  skip_bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> !curBad);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !ctl.init) |=> cfgErr);

  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.init && !ctl.finish) |=> $stable(resValid));
endmodule

// File: rtl/hier_cfg_select.sv
module hier_cfg_select #(
  parameter int NUM_CAND = 10,
  parameter int SZW      = 16,
  parameter int TW       = 16,
  parameter int EW       = 16,
  parameter logic [NUM_CAND*3*SZW-1:0] CAND_TABLE = {
    16'd16384, 16'd512, 16'd16,
    16'd2048,  16'd256, 16'd16,
    16'd16384, 16'd128, 16'd16,
    16'd4096,  16'd128, 16'd16,
    16'd8192,  16'd64,  16'd16,
    16'd2048,  16'd64,  16'd16,
    16'd2048,  16'd32,  16'd8,
    16'd0,     16'd2048, 16'd16,
    16'd0,     16'd1024, 16'd16,
    16'd0,     16'd256, 16'd16
  },
  parameter int REF_L1   = 32,
  parameter int REF_L2   = 256,
  parameter int REF_L3   = 16384,
  localparam int IW      = $clog2(NUM_CAND + 1)
)(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  output logic           evalReq,
  output logic [IW-1:0]  evalIdx,
  output logic [SZW-1:0] evalL1,
  output logic [SZW-1:0] evalL2,
  output logic [SZW-1:0] evalL3,
  input  logic           evalAck,
  input  logic [TW-1:0]  evalTime,
  input  logic [EW-1:0]  evalEnergy,
  output logic           done,
  output logic           resValid,
  output logic [IW-1:0]  resIdx,
  output logic [EW-1:0]  resEnergy,
  output logic           cfgErr
);
  hier_sel_pkg::selCtl_t ctl;
  logic curBad, curLast;

  hsel_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .evalAck (evalAck),
    .curBad  (curBad),
    .curLast (curLast),
    .ctl     (ctl),
    .evalReq (evalReq),
    .done    (done)
  );

  hsel_path #(
    .NUM_CAND   (NUM_CAND),
    .SZW        (SZW),
    .TW         (TW),
    .EW         (EW),
    .IW         (IW),
    .CAND_TABLE (CAND_TABLE),
    .REF_L1     (REF_L1),
    .REF_L2     (REF_L2),
    .REF_L3     (REF_L3)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .evalTime   (evalTime),
    .evalEnergy (evalEnergy),
    .curIdx     (evalIdx),
    .curL1      (evalL1),
    .curL2      (evalL2),
    .curL3      (evalL3),
    .curBad     (curBad),
    .curLast    (curLast),
    .resIdx     (resIdx),
    .resEnergy  (resEnergy),
    .resValid   (resValid),
    .cfgErr     (cfgErr)
  );
endmodule

// File: tb/hier_cfg_select_test.sv
module hier_cfg_select_test;
  localparam logic [479:0] BAD_TABLE = {
    16'd512,   16'd512, 16'd16,
    16'd2048,  16'd256, 16'd16,
    16'd16384, 16'd128, 16'd16,
    16'd4096,  16'd128, 16'd16,
    16'd8192,  16'd64,  16'd16,
    16'd2048,  16'd64,  16'd16,
    16'd2048,  16'd12,  16'd8,
    16'd0,     16'd2048, 16'd16,
    16'd0,     16'd1024, 16'd16,
    16'd0,     16'd256, 16'd16
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startA = 1'b0, startB = 1'b0;
  logic ack = 1'b0;
  logic [15:0] eTimeOut = '0, eEnOut = '0;

  logic reqA, reqB, doneA, doneB, valA, valB, errA, errB;
  logic [3:0] idxA, idxB, rIdxA, rIdxB;
  logic [15:0] a1, a2, a3, b1, b2, b3, rEA, rEB;

  always #2 clk = ~clk;

  hier_cfg_select uut (
    .clk(clk), .rstN(rstN), .start(startA),
    .evalReq(reqA), .evalIdx(idxA), .evalL1(a1), .evalL2(a2), .evalL3(a3),
    .evalAck(ack), .evalTime(eTimeOut), .evalEnergy(eEnOut),
    .done(doneA), .resValid(valA), .resIdx(rIdxA), .resEnergy(rEA), .cfgErr(errA));

  hier_cfg_select #(.CAND_TABLE(BAD_TABLE)) uutBad (
    .clk(clk), .rstN(rstN), .start(startB),
    .evalReq(reqB), .evalIdx(idxB), .evalL1(b1), .evalL2(b2), .evalL3(b3),
    .evalAck(ack), .evalTime(eTimeOut), .evalEnergy(eEnOut),
    .done(doneB), .resValid(valB), .resIdx(rIdxB), .resEnergy(rEB), .cfgErr(errB));

  int checks = 0, fails = 0;
  int cyc = 0;
  int startCyc = 0;
  int lat = 0;
  int eT [11];
  int eE [11];
  int tL1 [2][10];
  int tL2 [2][10];
  int tL3 [2][10];

  typedef struct {
    int which;
    int idx;
    int energy;
    bit err;
    int cycles;
  } expItem_t;

  expItem_t expQ [$];
  int reqQ [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ladderFine(input int w, input int i);
    int lo;
    if (tL1[w][i] == 0) return 1'b0;
    lo = tL1[w][i];
    if (tL2[w][i] != 0) begin
      if (tL2[w][i] < 2 * lo) return 1'b0;
      lo = tL2[w][i];
    end
    if (tL3[w][i] != 0 && tL3[w][i] < 2 * lo) return 1'b0;
    return 1'b1;
  endfunction

  // Evaluator model: checks request order and contents, answers after lat cycles
  wire        anyReq = reqA | reqB;
  wire [3:0]  anyIdx = reqA ? idxA : idxB;
  wire [15:0] any1 = reqA ? a1 : b1;
  wire [15:0] any2 = reqA ? a2 : b2;
  wire [15:0] any3 = reqA ? a3 : b3;
  wire        anyW = reqA ? 1'b0 : 1'b1;

  initial begin
    forever begin
      @(negedge clk);
      if (anyReq && !ack) begin
        repeat (lat) @(negedge clk);
        check(anyReq, "R8 request held", int'(anyReq), 1);
        if (reqQ.size() == 0) begin
          check(1'b0, "R3 unexpected request", int'(anyIdx), -1);
        end else begin
          int want;
          want = reqQ.pop_front();
          check(int'(anyIdx) == want, "R2/R3 request index", int'(anyIdx), want);
          if (want == 10) begin
            check(any1 == 16'd32 && any2 == 16'd256 && any3 == 16'd16384,
                  "R2 baseline sizes", int'(any3), 16384);
          end else begin
            check(int'(any1) == tL1[anyW][want] && int'(any2) == tL2[anyW][want] &&
                  int'(any3) == tL3[anyW][want], "R3 entry sizes",
                  int'(any2), tL2[anyW][want]);
          end
        end
        ack = 1'b1;
        eTimeOut = 16'(eT[anyIdx]);
        eEnOut = 16'(eE[anyIdx]);
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  // Monitor: pops the expected result when done appears
  initial begin
    forever begin
      @(negedge clk);
      if (doneA || doneB) begin
        int w;
        w = doneA ? 0 : 1;
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected done", w, -1);
        end else begin
          expItem_t e;
          int gi, ge, gc;
          bit gerr, gv;
          e = expQ.pop_front();
          gi = (w == 0) ? int'(rIdxA) : int'(rIdxB);
          ge = (w == 0) ? int'(rEA) : int'(rEB);
          gerr = (w == 0) ? errA : errB;
          gv = (w == 0) ? valA : valB;
          gc = cyc - startCyc;
          check(w == e.which, "R9 done source", w, e.which);
          check(gv, "R9 valid with done", int'(gv), 1);
          check(gi == e.idx, "R4/R5/R6 selected index", gi, e.idx);
          check(ge == e.energy, "R5/R6 selected energy", ge, e.energy);
          check(gerr == e.err, "R7 error flag", int'(gerr), int'(e.err));
          check(gc == e.cycles, "R10 scan length", gc, e.cycles);
          @(negedge clk);
          check(!doneA && !doneB, "R9 done one cycle", int'(doneA | doneB), 0);
          gv = (w == 0) ? valA : valB;
          check(gv, "R9 valid held", int'(gv), 1);
        end
      end
    end
  end

  task automatic runScan(input int w, input int latency, input bit extraStart);
    expItem_t e;
    int bi, be, rt, cy;
    bit er;
    lat = latency;
    bi = 10; be = eE[10]; rt = eT[10]; er = 1'b0; cy = latency + 1;
    reqQ.push_back(10);
    for (int i = 0; i < 10; i++) begin
      if (!ladderFine(w, i)) begin
        er = 1'b1;
        cy += 1;
      end else begin
        reqQ.push_back(i);
        cy += latency + 2;
        if (eT[i] <= rt && eE[i] < be) begin
          be = eE[i];
          bi = i;
        end
      end
    end
    e.which = w; e.idx = bi; e.energy = be; e.err = er; e.cycles = cy;
    expQ.push_back(e);
    @(negedge clk);
    if (w == 0) startA = 1'b1; else startB = 1'b1;
    @(negedge clk);
    startA = 1'b0; startB = 1'b0;
    startCyc = cyc;
    if (w == 0) begin
      check(!valA, "R9 valid cleared at start", int'(valA), 0);
      check(!errA, "R7 error cleared at start", int'(errA), 0);
    end else begin
      check(!valB, "R9 valid cleared at start", int'(valB), 0);
      check(!errB, "R7 error cleared at start", int'(errB), 0);
    end
    if (extraStart) begin
      repeat (3) @(negedge clk);
      if (w == 0) startA = 1'b1; else startB = 1'b1;
      @(negedge clk);
      startA = 1'b0; startB = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(input int t, input int en);
    for (int i = 0; i < 10; i++) begin
      eT[i] = t;
      eE[i] = en;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tL1[0] = '{16, 16, 16, 8, 16, 16, 16, 16, 16, 16};
    tL2[0] = '{256, 1024, 2048, 32, 64, 64, 128, 128, 256, 512};
    tL3[0] = '{0, 0, 0, 2048, 2048, 8192, 4096, 16384, 2048, 16384};
    tL1[1] = tL1[0];
    tL2[1] = tL2[0];
    tL3[1] = tL3[0];
    tL2[1][3] = 12;
    tL3[1][9] = 512;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!doneA && !doneB, "R1 done low", int'(doneA | doneB), 0);
    check(!valA && !valB, "R1 valid low", int'(valA | valB), 0);
    check(!reqA && !reqB, "R1 request low", int'(reqA | reqB), 0);
    check(!errA && !errB, "R1 error low", int'(errA | errB), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: distinct energies, all eligible
    fill(100, 0);
    for (int i = 0; i < 10; i++) eE[i] = 300 + 10 * i;
    eE[4] = 120; eT[10] = 100; eE[10] = 500;
    runScan(0, 0, 1'b0);

    // R8: the idle instance ignored every acknowledge
    check(!valB && !errB && !reqB, "R8 ack ignored while idle", int'(valB), 0);

    // R4: equal time eligible, slower rejected
    fill(100, 0);
    for (int i = 0; i < 10; i++) eE[i] = 200 + i;
    eT[2] = 101; eE[2] = 50;
    eE[7] = 60;
    eT[5] = 99; eE[5] = 70;
    eT[10] = 100; eE[10] = 500;
    runScan(0, 2, 1'b0);

    // R5 tie goes to lower index, R9 extra start ignored
    fill(90, 200);
    eE[3] = 80; eE[6] = 80;
    eT[10] = 100; eE[10] = 400;
    runScan(0, 1, 1'b1);

    // R6: all slower, an equal-energy tie keeps the baseline
    fill(150, 10);
    eT[8] = 100; eE[8] = 400;
    eT[10] = 100; eE[10] = 400;
    runScan(0, 0, 1'b0);

    // R7: bad entries 3 and 9 would win but are skipped
    fill(100, 200);
    eE[3] = 5; eE[9] = 6; eE[1] = 40;
    eT[10] = 100; eE[10] = 500;
    runScan(1, 1, 1'b0);

    // R6 + R7: no improvement, error still reported
    fill(100, 900);
    eT[10] = 100; eE[10] = 300;
    runScan(1, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule